// File: doc/BRIEF.md
# Packet Interrupt Delay Timer

This block decides when a DMA engine should raise its completion interrupt after traffic goes quiet. Each time a packet finishes, a timer starts from zero. If another packet starts before the timer runs out, the timer is cancelled. If the line stays idle for the programmed number of intervals, one interrupt is raised. A burst of closely spaced packets therefore shares a single interrupt, while a lone packet is still serviced within a bounded time.

Time is measured in intervals. A fixed prescaler divides the scatter-gather clock by `PRESCALE` (125 by default) to produce one interval tick. An 8-bit delay input sets how many intervals of silence are needed, and a value of zero turns the delay interrupt off. The result is held in a sticky flag until software acknowledges it. The interrupt line is that flag, gated by a nonzero delay setting.

Top module: `pkt_irq_delay_timer`

## Requirements
- R1: With delay D in the range 1..255, the flag rises exactly PRESCALE*D clock cycles after the clock edge that samples an end-of-packet strobe, provided no further strobe arrives in between.
- R2: A delay value of 0 never produces a timeout, so the flag stays 0 however long the timer has been armed.
- R3: The prescaler count stays within 0..PRESCALE-1. It is forced to 0 whenever the timer is armed, cancelled or times out.
- R4: An end-of-packet strobe arms the timer with an elapsed count of 0. A strobe that arrives while the timer is already running restarts it from 0.
- R5: A start-of-packet strobe without an end-of-packet strobe in the same cycle cancels a running timer, and no interrupt follows from it.
- R6: A timeout returns the timer to idle. It does not count again until the next end-of-packet strobe, so one idle period produces exactly one interrupt.
- R7: Once set, the flag stays 1 until an acknowledge is sampled.
- R8: The interrupt output equals the flag ANDed with (delay != 0).
- R9: An acknowledge clears the flag on the next edge. If a timeout and an acknowledge occur in the same cycle, the flag ends up set.
- R10: The delay value is compared at every interval tick. If the delay is lowered to a value at or below the elapsed count plus one, the timeout occurs on the next tick.
- R11: If start-of-packet and end-of-packet strobes arrive in the same cycle, the end-of-packet strobe takes effect and the timer re-arms from 0.
- R12: After reset the flag and the interrupt are 0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scatter-gather clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pkt_end_i | input | 1 | One-cycle strobe marking the end of a packet |
| pkt_start_i | input | 1 | One-cycle strobe marking the start of a new packet |
| delay_i | input | DELAY_W | Timeout length in intervals; 0 disables the interrupt |
| irq_ack_i | input | 1 | Acknowledge that clears the sticky flag |
| irq_flag_o | output | 1 | Sticky delay-timeout flag |
| irq_o | output | 1 | Interrupt line: flag gated by a nonzero delay |

## Verification
The bench builds the block with its default parameters: an 8-bit delay and a prescale of 125. This keeps the interval length tested exactly as it will be used. Because the largest delay (255 intervals, 31,875 cycles) fits easily in the run, both the one-interval edge and the full-scale edge are checked to the exact cycle. Running at the real prescale also allows the delay setting to be changed partway through an interval, which checks that a lowered value fires on the next tick and not at once.

// File: rtl/pid_pkg.sv
`timescale 1ns/1ps
package pid_pkg;
  typedef enum logic {
    TMR_IDLE  = 1'b0,
    TMR_ARMED = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/pid_prescaler.sv
`timescale 1ns/1ps
module pid_prescaler #(
  parameter int unsigned PRESCALE = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | run_i;
  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R3
  prescale_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R3
  prescale_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pid_interval_cnt.sv
`timescale 1ns/1ps
module pid_interval_cnt
  import pid_pkg::*;
#(
  parameter int unsigned DELAY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eop_i,
  input  logic               sop_i,
  input  logic               tick_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               armed_o,
  output logic               clr_o,
  output logic               timeout_o
);
  tmr_state_e         state_q, state_d;
  logic [DELAY_W-1:0] cnt_q, cnt_d;
  logic [DELAY_W:0]   elapsed_nxt;
  logic               hit;
  logic               reg_en;

  assign elapsed_nxt = {1'b0, cnt_q} + 1'b1;
  assign hit         = (delay_i != '0) && (elapsed_nxt >= {1'b0, delay_i});
  assign armed_o     = (state_q == TMR_ARMED);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    timeout_o = 1'b0;
    clr_o     = 1'b0;
    if (eop_i) begin
      state_d = TMR_ARMED;
      cnt_d   = '0;
      clr_o   = 1'b1;
    end else if (sop_i) begin
      state_d = TMR_IDLE;
      cnt_d   = '0;
      clr_o   = 1'b1;
    end else if ((state_q == TMR_ARMED) && tick_i) begin
      if (hit) begin
        timeout_o = 1'b1;
        state_d   = TMR_IDLE;
        cnt_d     = '0;
        clr_o     = 1'b1;
      end else if (cnt_q != '1) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign reg_en = eop_i | sop_i | tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R4
  eop_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_i |=> (state_q == TMR_ARMED && cnt_q == '0));

  // R5
  sop_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && !eop_i) |=> (state_q == TMR_IDLE));

  // R6
  timeout_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> (state_q == TMR_IDLE));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_IDLE && !eop_i) |=> (state_q == TMR_IDLE));

  // R2
  zero_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delay_i == '0) |-> !timeout_o);
endmodule

// File: rtl/pid_irq_flag.sv
`timescale 1ns/1ps
module pid_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (ack_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ack_i) |=> flag_q);

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !flag_q);

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/pkt_irq_delay_timer.sv
`timescale 1ns/1ps
module pkt_irq_delay_timer #(
  parameter int unsigned DELAY_W  = 8,
  parameter int unsigned PRESCALE = 125
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_end_i,
  input  logic               pkt_start_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic               irq_ack_i,
  output logic               irq_flag_o,
  output logic               irq_o
);
  logic rst_meta_q, rst_sync_q;
  logic armed, clr, tick, timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pid_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .clr_i  (clr),
    .run_i  (armed),
    .tick_o (tick)
  );

  pid_interval_cnt #(.DELAY_W(DELAY_W)) u_ivl (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .eop_i     (pkt_end_i),
    .sop_i     (pkt_start_i),
    .tick_i    (tick),
    .delay_i   (delay_i),
    .armed_o   (armed),
    .clr_o     (clr),
    .timeout_o (timeout)
  );

  pid_irq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .set_i  (timeout),
    .ack_i  (irq_ack_i),
    .flag_o (irq_flag_o)
  );

  assign irq_o = irq_flag_o & (delay_i != '0);

  // R12
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    $rose(rst_sync_q) |-> (!irq_flag_o && !armed));
endmodule

// File: tb/sim_pkt_irq_delay_timer.sv
`timescale 1ns/1ps
module sim_pkt_irq_delay_timer;
  localparam int unsigned DW = 8;
  localparam int unsigned PS = 125;
  localparam int NV = 4;
  localparam logic [DW-1:0] DLY_TAB [NV] = '{8'd1, 8'd2, 8'd3, 8'd7};
  localparam int            EXP_TAB [NV] = '{125, 250, 375, 875};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eop = 1'b0;
  logic          sop = 1'b0;
  logic [DW-1:0] dly = '0;
  logic          ack = 1'b0;
  logic          flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pkt_irq_delay_timer #(.DELAY_W(DW), .PRESCALE(PS)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pkt_end_i   (eop),
    .pkt_start_i (sop),
    .delay_i     (dly),
    .irq_ack_i   (ack),
    .irq_flag_o  (flag),
    .irq_o       (irq)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic e, input logic s, input logic a);
    @(negedge clk);
    eop = e; sop = s; ack = a;
    @(negedge clk);
    eop = 1'b0; sop = 1'b0; ack = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    // R12 reset state
    chk(flag, 1'b0, "R12 flag");
    chk(irq, 1'b0, "R12 irq");

    // R1 table walk, with R7, R8 and R9 on each entry
    for (int i = 0; i < NV; i++) begin
      dly = DLY_TAB[i];
      pulse(1'b1, 1'b0, 1'b0);
      wait_n(EXP_TAB[i] - 1);
      chk(flag, 1'b0, "R1 early");
      wait_n(1);
      chk(flag, 1'b1, "R1 edge");
      chk(irq, 1'b1, "R8 irq");
      wait_n(10);
      chk(flag, 1'b1, "R7 sticky");
      pulse(1'b0, 1'b0, 1'b1);
      chk(flag, 1'b0, "R9 ack");
    end

    // R10 lower the delay partway through the fourth interval
    dly = 8'd10;
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(385);
    dly = 8'd2;
    wait_n(114);
    chk(flag, 1'b0, "R10 before tick");
    wait_n(1);
    chk(flag, 1'b1, "R10 next tick");
    pulse(1'b0, 1'b0, 1'b1);
    // R6 no re-arm without a new end strobe
    wait_n(600);
    chk(flag, 1'b0, "R6 single irq");

    // R5 start strobe cancels
    dly = 8'd2;
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(100);
    pulse(1'b0, 1'b1, 1'b0);
    wait_n(600);
    chk(flag, 1'b0, "R5 cancel");

    // R11 both strobes together re-arm
    dly = 8'd1;
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(50);
    pulse(1'b1, 1'b1, 1'b0);
    wait_n(124);
    chk(flag, 1'b0, "R11 early");
    wait_n(1);
    chk(flag, 1'b1, "R11 edge");
    pulse(1'b0, 1'b0, 1'b1);

    // R4 restart while running
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(100);
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(124);
    chk(flag, 1'b0, "R4 early");
    wait_n(1);
    chk(flag, 1'b1, "R4 edge");
    pulse(1'b0, 1'b0, 1'b1);

    // R9 timeout and acknowledge in the same cycle
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(124);
    ack = 1'b1;
    wait_n(1);
    ack = 1'b0;
    chk(flag, 1'b1, "R9 set wins");
    pulse(1'b0, 1'b0, 1'b1);
    chk(flag, 1'b0, "R9 cleared");

    // R2 zero delay never fires
    dly = 8'd0;
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(400);
    chk(flag, 1'b0, "R2 flag");
    chk(irq, 1'b0, "R2 irq");

    // R8 gating by delay value
    dly = 8'd1;
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(125);
    dly = 8'd0;
    #1;
    chk(irq, 1'b0, "R8 gated");
    chk(flag, 1'b1, "R8 flag kept");
    dly = 8'd1;
    #1;
    chk(irq, 1'b1, "R8 ungated");
    pulse(1'b0, 1'b0, 1'b1);

    // R1 full-scale delay; R3 is covered by the exact cycle count
    dly = 8'd255;
    pulse(1'b1, 1'b0, 1'b0);
    wait_n(31874);
    chk(flag, 1'b0, "R1 max early");
    wait_n(1);
    chk(flag, 1'b1, "R3 max edge");

    finish_run();
  end
endmodule